// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Mode Fields

This block is a memory-mapped general-purpose I/O peripheral for sixteen pins. The pins form four banks of uneven size: two, four, four and six pins, beginning at global pins 0, 2, 6 and 10. Each bank has a data register and a configuration register. A single shared register chooses, per global pin, between open-drain and push-pull drive. Software reaches these registers through a simple single-cycle 32-bit register port.

Each pin carries a 4-bit mode field. Mode 0x8 makes the pin an output. Every other code, including the input code 0x1, leaves the pin undriven and treats it as an input. Output pins drive the level held in the data register, unless open-drain is selected. Input pins are sampled through a two-flop synchronizer, and the synchronized level is returned when the data register is read.

Top module: `pinbank_gpio`

## Requirements
- R1: In the cycle after reset is asserted, pin_oe and pin_out are all 0. After reset, every mode field reads 0x1, every data latch is 0 and every open-drain bit is 0.
- R2: The data registers of banks 0 to 3 sit at byte addresses 0x170, 0x174, 0x178 and 0x17C. The configuration registers are at 0x180, 0x184, 0x188 and 0x18C. The open-drain register is at 0x190. A read of any other address returns 0.
- R3: A bank's configuration register holds the mode of bank-local pin i in bits [4i+3:4i]. Written modes read back unchanged. Bits at and above 4 × (bank pin count) read 0.
- R4: A pin whose mode is 0x8 and whose open-drain bit is 0 has pin_oe = 1 and pin_out equal to its data latch. Both take effect on the second rising edge after the register write.
- R5: A pin whose mode is not 0x8 has pin_oe = 0 and pin_out = 0.
- R6: A pin in mode 0x8 with its open-drain bit set has pin_out = 0. Its pin_oe equals the inverse of its data latch.
- R7: Reading a data register returns, for each bank-local bit, the data latch if the pin's mode is 0x8, and otherwise the level of the pin input after two synchronizer flops. A change on pin_in is therefore not visible to a read issued in the same cycle.
- R8: Data register bits at and above the bank's pin count read 0 and ignore writes. Open-drain register bits 31:16 read 0. Bit p of the open-drain register belongs to global pin p.
- R9: When a read and a write target the same register in the same cycle, the read returns the value held before the write. The next read returns the new value.
- R10: rdata is registered. It shows the selected register one cycle after rd_en, and shows 0 in any cycle that follows a cycle with rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin input levels |
| pin_out | output | 16 | Registered pin output levels |
| pin_oe | output | 16 | Registered pin output enables |

## Verification
A register read and a register write can fall in the same cycle on the same address. A synchronizer update and a data register read can also coincide. The bench raises rd_en and wr_en together on one data register and expects the old contents, then the new contents on the following read. It also changes a pin input in the same cycle as a read of that pin and expects the stale level. Beyond these directed cases, constrained random writes of modes, data and open-drain bits are followed by pin and register checks against a bench model.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int NUM_BANKS = 4;
  localparam int MODE_W    = 4;
  localparam logic [3:0] MODE_IN  = 4'h1;
  localparam logic [3:0] MODE_OUT = 4'h8;
  localparam int DATA_BASE = 'h170;
  localparam int CFG_BASE  = 'h180;
  localparam int ODRV_ADDR = 'h190;

  function automatic int bank_size(input int b);
    case (b)
      0:       return 2;
      1:       return 4;
      2:       return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int bank_base(input int b);
    int acc;
    acc = 0;
    for (int k = 0; k < NUM_BANKS; k++)
      if (k < b) acc += bank_size(k);
    return acc;
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
#(
  parameter int PINS   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   sync_in,
  output logic [PINS-1:0]   is_out,
  output logic [PINS-1:0]   latch,
  output logic [DATA_W-1:0] data_rd,
  output logic [DATA_W-1:0] cfg_rd
);
  localparam int CFG_BITS = PINS * MODE_W;

  logic [PINS-1:0]   latch_q;
  logic [MODE_W-1:0] mode_q [PINS];

  always_ff @(posedge clk) begin
    if (rst)          latch_q <= '0;
    else if (data_we) latch_q <= wdata[PINS-1:0];
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)         mode_q[i] <= MODE_IN;
      else if (cfg_we) mode_q[i] <= wdata[i*MODE_W +: MODE_W];
    end
    assign is_out[i] = (mode_q[i] == MODE_OUT);
  end

  assign latch = latch_q;

  always_comb begin
    data_rd = '0;
    cfg_rd  = '0;
    for (int i = 0; i < PINS; i++) begin
      data_rd[i] = is_out[i] ? latch_q[i] : sync_in[i];
      cfg_rd[i*MODE_W +: MODE_W] = mode_q[i];
    end
  end

  if (CFG_BITS > DATA_W) begin : g_bad
    initial $error("bank mode fields exceed register width");
  end
endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] is_out,
  input  logic [PINS-1:0] latch,
  input  logic [PINS-1:0] odrain,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe
);
  logic [PINS-1:0] out_d;
  logic [PINS-1:0] oe_d;

  always_comb begin
    for (int p = 0; p < PINS; p++) begin
      if (!is_out[p]) begin
        oe_d[p]  = 1'b0;
        out_d[p] = 1'b0;
      end else if (odrain[p]) begin
        oe_d[p]  = ~latch[p];
        out_d[p] = 1'b0;
      end else begin
        oe_d[p]  = 1'b1;
        out_d[p] = latch[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= out_d;
      pin_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int TOTAL_PINS = bank_base(NUM_BANKS);
  localparam logic [ADDR_W-1:0] OD_A = ADDR_W'(ODRV_ADDR);

  logic [NUM_PINS-1:0] sync_all;
  logic [NUM_PINS-1:0] is_out_all;
  logic [NUM_PINS-1:0] latch_all;
  logic [NUM_PINS-1:0] odrain_q;
  logic [DATA_W-1:0]   bank_data_rd [NUM_BANKS];
  logic [DATA_W-1:0]   bank_cfg_rd  [NUM_BANKS];
  logic [NUM_BANKS-1:0] data_hit;
  logic [NUM_BANKS-1:0] cfg_hit;
  logic                od_hit;
  logic [DATA_W-1:0]   rd_mux;

  if (TOTAL_PINS != NUM_PINS) begin : g_bad
    initial $error("bank sizes do not add up to NUM_PINS");
  end

  pinbank_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (sync_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BP = bank_size(b);
    localparam int BB = bank_base(b);
    assign data_hit[b] = (addr == ADDR_W'(DATA_BASE + 4 * b));
    assign cfg_hit[b]  = (addr == ADDR_W'(CFG_BASE + 4 * b));

    pinbank_bank #(.PINS(BP), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .data_we (wr_en && data_hit[b]),
      .cfg_we  (wr_en && cfg_hit[b]),
      .wdata   (wdata),
      .sync_in (sync_all[BB +: BP]),
      .is_out  (is_out_all[BB +: BP]),
      .latch   (latch_all[BB +: BP]),
      .data_rd (bank_data_rd[b]),
      .cfg_rd  (bank_cfg_rd[b])
    );
  end

  assign od_hit = (addr == OD_A);

  always_ff @(posedge clk) begin
    if (rst)                  odrain_q <= '0;
    else if (wr_en && od_hit) odrain_q <= wdata[NUM_PINS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (data_hit[b]) rd_mux = bank_data_rd[b];
      if (cfg_hit[b])  rd_mux = bank_cfg_rd[b];
    end
    if (od_hit) rd_mux = DATA_W'(odrain_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  pinbank_drive #(.PINS(NUM_PINS)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .is_out  (is_out_all),
    .latch   (latch_all),
    .odrain  (odrain_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/pinbank_gpio_chk.sv
module pinbank_gpio_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (addr == ADDR_W'('h170 + 4 * k)) mapped = 1'b1;
      if (addr == ADDR_W'('h180 + 4 * k)) mapped = 1'b1;
    end
    if (addr == ADDR_W'('h190)) mapped = 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == '0)); // R2

  AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'('h180)) |=> (rdata[DATA_W-1:8] == '0)); // R3

  AST_NO_HIGH_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~pin_oe) == '0)); // R5

  AST_OD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'('h190)) |=> (rdata[DATA_W-1:NUM_PINS] == '0)); // R8

  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> (rdata == '0)); // R10
endmodule

bind pinbank_gpio pinbank_gpio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pinbank_gpio_tb.sv
module pinbank_gpio_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_latch = '0;
  logic [15:0] m_od = '0;
  logic [3:0]  m_mode [16];

  always #5 clk = ~clk;

  pinbank_gpio u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int bsize(input int b);
    return (b == 0) ? 2 : (b == 3) ? 6 : 4;
  endfunction
  function automatic int bbase(input int b);
    return (b == 0) ? 0 : (b == 1) ? 2 : (b == 2) ? 6 : 10;
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      if (a == 12'h170 + 12'(4 * b))
        for (int i = 0; i < bsize(b); i++) m_latch[bbase(b) + i] = d[i];
      if (a == 12'h180 + 12'(4 * b))
        for (int i = 0; i < bsize(b); i++) m_mode[bbase(b) + i] = d[4*i +: 4];
    end
    if (a == 12'h190) m_od = d[15:0];
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 4; b++) begin
      if (a == 12'h170 + 12'(4 * b))
        for (int i = 0; i < bsize(b); i++)
          r[i] = (m_mode[bbase(b)+i] == 4'h8) ? m_latch[bbase(b)+i] : pin_in[bbase(b)+i];
      if (a == 12'h180 + 12'(4 * b))
        for (int i = 0; i < bsize(b); i++) r[4*i +: 4] = m_mode[bbase(b)+i];
    end
    if (a == 12'h190) r = {16'h0, m_od};
    return r;
  endfunction

  function automatic logic [15:0] model_oe();
    logic [15:0] v;
    for (int p = 0; p < 16; p++)
      v[p] = (m_mode[p] == 4'h8) && (!m_od[p] || !m_latch[p]);
    return v;
  endfunction

  function automatic logic [15:0] model_out();
    logic [15:0] v;
    for (int p = 0; p < 16; p++)
      v[p] = (m_mode[p] == 4'h8) && !m_od[p] && m_latch[p];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pins(input string req);
    check(req, {16'h0, pin_oe}, {16'h0, model_oe()});
    check(req, {16'h0, pin_out}, {16'h0, model_out()});
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] expv;
    void'($urandom(32'h5EED_0A11));
    for (int p = 0; p < 16; p++) m_mode[p] = 4'h1;

    repeat (3) @(negedge clk);
    check("R1", {16'h0, pin_oe}, 32'h0);
    check("R1", {16'h0, pin_out}, 32'h0);
    rst = 1'b0;
    bus_read(12'h18C, rd); check("R1", rd, 32'h0011_1111);
    bus_read(12'h170, rd); check("R1", rd, 32'h0);
    bus_read(12'h190, rd); check("R1", rd, 32'h0);
    bus_read(12'h194, rd); check("R2", rd, 32'h0);
    bus_read(12'h16C, rd); check("R2", rd, 32'h0);
    @(negedge clk); check("R10", rdata, 32'h0);

    bus_write(12'h180, 32'hFFFF_FF88);
    bus_read(12'h180, rd); check("R3", rd, 32'h0000_0088);
    bus_write(12'h170, 32'hFFFF_FFFF);
    bus_read(12'h170, rd); check("R8", rd, 32'h0000_0003);
    bus_write(12'h190, 32'hFFFF_0000);
    bus_read(12'h190, rd); check("R8", rd, 32'h0);

    // R4: outputs change on the second edge after the write
    bus_write(12'h170, 32'h0000_0001);
    check("R4", {31'h0, pin_out[1]}, 32'h1);
    @(negedge clk);
    check("R4", {16'h0, pin_out}, 32'h0000_0001);
    check("R4", {16'h0, pin_oe}, 32'h0000_0003);

    // R6: open-drain on both bank 0 pins
    bus_write(12'h190, 32'h0000_0003);
    settle();
    check("R6", {16'h0, pin_out}, 32'h0);
    check("R6", {16'h0, pin_oe}, 32'h0000_0002);

    // R7: same-cycle pin change is not yet visible
    bus_write(12'h184, 32'h0000_1111);
    pin_in = 16'h0000; settle();
    @(negedge clk);
    addr = 12'h174; rd_en = 1'b1; pin_in = 16'h003C;
    @(negedge clk);
    rd_en = 1'b0;
    check("R7", rdata, 32'h0);
    settle();
    bus_read(12'h174, rd); check("R7", rd, 32'h0000_000F);

    // R9: read and write on the same register in one cycle
    bus_write(12'h190, 32'h0);
    bus_write(12'h170, 32'h0000_0002);
    @(negedge clk);
    addr = 12'h170; wdata = 32'h0000_0001; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9", rdata, 32'h0000_0002);
    model_write(12'h170, 32'h0000_0001);
    bus_read(12'h170, rd); check("R9", rd, 32'h0000_0001);

    // R5: a stray mode code leaves the pin undriven
    bus_write(12'h180, 32'h0000_0083);
    settle();
    check("R5", {31'h0, pin_oe[0]}, 32'h0);
    check("R5", {31'h0, pin_out[0]}, 32'h0);

    // constrained random mix: R3 R4 R5 R6 R7 R8
    for (int it = 0; it < 300; it++) begin
      int op;
      int b;
      logic [31:0] d;
      logic [11:0] ra;
      op = int'($urandom_range(0, 3));
      b  = int'($urandom_range(0, 3));
      d  = $urandom();
      if (op == 0) begin
        for (int i = 0; i < 8; i++) begin
          int sel;
          sel = int'($urandom_range(0, 3));
          d[4*i +: 4] = (sel == 0) ? 4'h1 : (sel == 3) ? 4'($urandom()) : 4'h8;
        end
        bus_write(12'h180 + 12'(4 * b), d);
      end else if (op == 1) begin
        bus_write(12'h170 + 12'(4 * b), d);
      end else if (op == 2) begin
        bus_write(12'h190, d);
      end else begin
        pin_in = 16'($urandom());
      end
      settle();
      check_pins("R4 R5 R6");
      case ($urandom_range(0, 3))
        0: ra = 12'h170 + 12'(4 * $urandom_range(0, 3));
        1: ra = 12'h180 + 12'(4 * $urandom_range(0, 3));
        2: ra = 12'h190;
        default: ra = 12'($urandom_range(0, 4095));
      endcase
      expv = model_read(ra);
      bus_read(ra, rd);
      check("R3 R7 R8", rd, expv);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule